// File: doc/BRIEF.md
# Power-Down Sequencer with Qualified Wake-Up

This block sequences the low-power states of a small 8-bit microcontroller core. The instruction decoder gives it one-cycle strobes for five opcodes: a CPU clock gate, an oscillator stop, a port float, a float of every output, and a float cancel. From these strobes it drives an oscillator enable, an enable for the CPU clock gate and a seven-group pin float (tristate) vector. The float groups that are actually released depend on whether the core fetches from internal or external program memory.

Wake-up comes from the active-low interrupt pin or the active-low reset pin. A low level restarts the oscillator at once. The request is accepted only if it is still low when a set number of ALE pulses have been seen. For an oscillator-stop halt, only pulses that arrive while the oscillator-stable input is high are counted. On acceptance the block releases the CPU clock and gives a one-cycle resume pulse with one of three actions: continue after the power-down instruction, vector to the interrupt address, or restart from address zero.

A separate standby pin overrides everything else. Driving it low stops the oscillator and floats every pin group. Raising it again restarts the oscillator. The block then returns to its previous state, or starts wake qualification if a request pin is low.

Top module: `pd_wake_ctrl`

## Requirements
- R1: After synchronous reset, osc_en=1, cpu_clk_en=1, float_en=0 and resume_valid=0.
- R2: The clock-gate strobe, taken while running, clears cpu_clk_en after the next edge and leaves osc_en at 1.
- R3: The oscillator-stop strobe, taken while running, clears both osc_en and cpu_clk_en after the next edge.
- R4: The port-float strobe selects float_en bits p1 (bit 0), p2 low nibble (bit 1), p2 high nibble (bit 2) and bus (bit 3), giving 7'h0F. With ext_rom=1 it selects only bits 0 and 2, giving 7'h05.
- R5: The all-float strobe additionally selects ALE (bit 4), PSEN (bit 5) and the control strobes PROG/WR/RD/T0 (bit 6), giving 7'h7F. With ext_rom=1 it selects only bits 0, 2 and 6, giving 7'h45.
- R6: A float selection is cleared at the next edge by the float-cancel strobe, by int_n low or by reset_n low. A cancel wins over a set in the same cycle.
- R7: While halted, a low request (int_n or reset_n) sets osc_en to 1. The request is accepted on the edge where the ALE_NEED-th ALE tick arrives with the request still low. That edge sets cpu_clk_en=1 and gives resume_valid for exactly one cycle.
- R8: If the request goes high before acceptance, the tick count restarts from zero and the block returns to the halt state it came from.
- R9: ALE ticks are counted only while osc_stable is 1.
- R10: resume_kind is 2 when reset_n is low at acceptance. Otherwise it is 1 when int_en=1 and in_isr=0, and 0 in all other cases. Reset has priority over interrupt.
- R11: stby_n low forces osc_en=0, cpu_clk_en=0 and float_en=7'h7F from the next edge on. After release, osc_en returns to 1 and all groups stay floated until osc_stable. With both request pins high the block then returns to its prior state, with no resume pulse and with any float selection restored.
- R12: A standby release with a request pin low goes through oscillator settling and then through the same ALE qualification as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| op_halt | input | 1 | Strobe: gate the CPU clock |
| op_stop | input | 1 | Strobe: stop the oscillator |
| op_flt | input | 1 | Strobe: float the port groups |
| op_fltt | input | 1 | Strobe: float all output groups |
| op_fres | input | 1 | Strobe: cancel any float |
| int_n | input | 1 | Interrupt pin, active low |
| reset_n | input | 1 | Reset pin, active low |
| stby_n | input | 1 | Standby control pin, low enters standby |
| int_en | input | 1 | Interrupts enabled in the core |
| in_isr | input | 1 | Core is inside an interrupt routine |
| ext_rom | input | 1 | Core fetches from external program memory |
| osc_stable | input | 1 | Oscillator has settled |
| ale_tick | input | 1 | One-cycle pulse per ALE from the timing generator |
| osc_en | output | 1 | Oscillator run enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| float_en | output | 7 | Per-group float enables (bit map in R4/R5) |
| resume_valid | output | 1 | One-cycle pulse on accepted wake-up |
| resume_kind | output | 2 | 0 continue, 1 vector to interrupt, 2 restart at zero |

## Verification
A wrong sequencer state shows on osc_en or cpu_clk_en one edge after the stimulus, because both are registered from the next state. A stale or wrongly cleared tick count shows as a resume pulse one ALE tick too early or too late. This is exercised by dropping the request after a single tick and then requalifying, and by giving ticks while the oscillator is still settling. A float mode that was lost or kept too long shows in float_en one edge after a cancel, or when standby is released and the remembered float groups reappear.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  localparam int FLT_N    = 7;
  localparam int FB_P1    = 0;
  localparam int FB_P2LO  = 1;
  localparam int FB_P2HI  = 2;
  localparam int FB_BUS   = 3;
  localparam int FB_ALE   = 4;
  localparam int FB_PSEN  = 5;
  localparam int FB_CTL   = 6;

  typedef enum logic [2:0] {
    S_RUN    = 3'd0,
    S_GATE   = 3'd1,
    S_OSCOFF = 3'd2,
    S_STBY   = 3'd3,
    S_WARM   = 3'd4,
    S_QUAL   = 3'd5
  } pd_state_e;

  typedef enum logic [1:0] {
    F_NONE  = 2'd0,
    F_PORTS = 2'd1,
    F_ALL   = 2'd2
  } fmode_e;

  typedef enum logic [1:0] {
    RES_CONT = 2'd0,
    RES_VEC  = 2'd1,
    RES_ZERO = 2'd2
  } resume_e;

  // Which pin groups a float mode releases, for the current fetch source.
  function automatic logic [FLT_N-1:0] float_map(fmode_e m, logic ext);
    logic [FLT_N-1:0] v;
    v = '0;
    case (m)
      F_PORTS: begin
        v[FB_P1]   = 1'b1;
        v[FB_P2HI] = 1'b1;
        v[FB_P2LO] = !ext;
        v[FB_BUS]  = !ext;
      end
      F_ALL: begin
        v[FB_P1]   = 1'b1;
        v[FB_P2HI] = 1'b1;
        v[FB_CTL]  = 1'b1;
        v[FB_P2LO] = !ext;
        v[FB_BUS]  = !ext;
        v[FB_ALE]  = !ext;
        v[FB_PSEN] = !ext;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pdw_wake_qual.sv
module pdw_wake_qual #(
  parameter int ALE_NEED = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic req,
  input  logic ale_tick,
  input  logic osc_stable,
  output logic done
);

  localparam int CNT_W = (ALE_NEED > 1) ? $clog2(ALE_NEED) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ALE_NEED - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             step_ok;

  assign step_ok = ale_tick && osc_stable;
  assign done    = active && req && step_ok && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!active || !req) begin
      cnt_q <= '0;
    end else if (step_ok) begin
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R8
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> cnt_q == '0);

  // R9
  cnt_hold_unstable_chk: assert property (@(posedge clk) disable iff (rst)
    (active && req && !osc_stable) |=> $stable(cnt_q));

endmodule

// File: rtl/pdw_float_ctl.sv
module pdw_float_ctl
  import pdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             op_flt,
  input  logic             op_fltt,
  input  logic             op_fres,
  input  logic             pin_cancel,
  input  logic             ext_rom,
  input  logic             stby_float,
  output logic [FLT_N-1:0] float_en
);

  fmode_e fmode_q, fmode_d;
  logic   cancel;

  assign cancel = pin_cancel || (run && op_fres);

  always_comb begin
    fmode_d = fmode_q;
    if (cancel) begin
      fmode_d = F_NONE;
    end else if (run && op_fltt) begin
      fmode_d = F_ALL;
    end else if (run && op_flt) begin
      fmode_d = F_PORTS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmode_q  <= F_NONE;
      float_en <= '0;
    end else begin
      fmode_q  <= fmode_d;
      float_en <= stby_float ? '1 : float_map(fmode_d, ext_rom);
    end
  end

  // R6
  cancel_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |=> fmode_q == F_NONE);

  // R11
  stby_all_float_chk: assert property (@(posedge clk) disable iff (rst)
    stby_float |=> &float_en);

endmodule

// File: rtl/pdw_seq.sv
module pdw_seq
  import pdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_halt,
  input  logic       op_stop,
  input  logic       req,
  input  logic       reset_n,
  input  logic       int_en,
  input  logic       in_isr,
  input  logic       stby_n,
  input  logic       osc_stable,
  input  logic       qual_done,
  output logic       run,
  output logic       in_qual,
  output logic       stby_float,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       resume_valid,
  output logic [1:0] resume_kind
);

  pd_state_e state_q, state_d;
  pd_state_e home_q, home_d;
  logic      fire;
  resume_e   kind_d;

  assign run     = (state_q == S_RUN);
  assign in_qual = (state_q == S_QUAL);
  assign fire    = in_qual && qual_done && stby_n;

  always_comb begin
    if (!reset_n) begin
      kind_d = RES_ZERO;
    end else if (int_en && !in_isr) begin
      kind_d = RES_VEC;
    end else begin
      kind_d = RES_CONT;
    end
  end

  always_comb begin
    home_d = home_q;
    if (state_q inside {S_RUN, S_GATE, S_OSCOFF}) begin
      home_d = state_q;
    end
  end

  always_comb begin
    state_d = state_q;
    if (!stby_n) begin
      state_d = S_STBY;
    end else begin
      case (state_q)
        S_RUN: begin
          if (op_stop) begin
            state_d = S_OSCOFF;
          end else if (op_halt) begin
            state_d = S_GATE;
          end
        end
        S_GATE, S_OSCOFF: begin
          if (req) begin
            state_d = S_QUAL;
          end
        end
        S_STBY: state_d = S_WARM;
        S_WARM: begin
          if (osc_stable) begin
            state_d = req ? S_QUAL : home_q;
          end
        end
        S_QUAL: begin
          if (!req) begin
            state_d = home_q;
          end else if (qual_done) begin
            state_d = S_RUN;
          end
        end
        default: state_d = S_RUN;
      endcase
    end
  end

  assign stby_float = (state_d == S_STBY) || (state_d == S_WARM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_RUN;
      home_q       <= S_RUN;
      osc_en       <= 1'b1;
      cpu_clk_en   <= 1'b1;
      resume_valid <= 1'b0;
      resume_kind  <= RES_CONT;
    end else begin
      state_q      <= state_d;
      home_q       <= home_d;
      osc_en       <= !((state_d == S_OSCOFF) || (state_d == S_STBY));
      cpu_clk_en   <= (state_d == S_RUN);
      resume_valid <= fire;
      if (fire) begin
        resume_kind <= kind_d;
      end
    end
  end

  // R3
  osc_off_gates_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !cpu_clk_en);

  // R7
  resume_single_chk: assert property (@(posedge clk) disable iff (rst)
    resume_valid |=> !resume_valid);

  // R7
  resume_clk_on_chk: assert property (@(posedge clk) disable iff (rst)
    resume_valid |-> cpu_clk_en);

  // R9
  qual_osc_on_chk: assert property (@(posedge clk) disable iff (rst)
    in_qual |-> osc_en);

  // R10
  reset_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (resume_valid && !$past(reset_n)) |-> resume_kind == RES_ZERO);

  // R11
  stby_stops_chk: assert property (@(posedge clk) disable iff (rst)
    !stby_n |=> (!osc_en && !cpu_clk_en));

  // R2
  halt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (run && op_halt && !op_stop && stby_n) |=> (osc_en && !cpu_clk_en));

endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
  import pdw_pkg::*;
#(
  parameter int ALE_NEED = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_halt,
  input  logic             op_stop,
  input  logic             op_flt,
  input  logic             op_fltt,
  input  logic             op_fres,
  input  logic             int_n,
  input  logic             reset_n,
  input  logic             stby_n,
  input  logic             int_en,
  input  logic             in_isr,
  input  logic             ext_rom,
  input  logic             osc_stable,
  input  logic             ale_tick,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic [FLT_N-1:0] float_en,
  output logic             resume_valid,
  output logic [1:0]       resume_kind
);

  logic req;
  logic run;
  logic in_qual;
  logic stby_float;
  logic qual_done;

  assign req = !int_n || !reset_n;

  pdw_wake_qual #(.ALE_NEED(ALE_NEED)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .active     (in_qual),
    .req        (req),
    .ale_tick   (ale_tick),
    .osc_stable (osc_stable),
    .done       (qual_done)
  );

  pdw_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .op_halt      (op_halt),
    .op_stop      (op_stop),
    .req          (req),
    .reset_n      (reset_n),
    .int_en       (int_en),
    .in_isr       (in_isr),
    .stby_n       (stby_n),
    .osc_stable   (osc_stable),
    .qual_done    (qual_done),
    .run          (run),
    .in_qual      (in_qual),
    .stby_float   (stby_float),
    .osc_en       (osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .resume_valid (resume_valid),
    .resume_kind  (resume_kind)
  );

  pdw_float_ctl u_float (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .op_flt     (op_flt),
    .op_fltt    (op_fltt),
    .op_fres    (op_fres),
    .pin_cancel (req),
    .ext_rom    (ext_rom),
    .stby_float (stby_float),
    .float_en   (float_en)
  );

endmodule

// File: tb/tb_pd_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pd_wake_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_halt = 0, op_stop = 0, op_flt = 0, op_fltt = 0, op_fres = 0;
  logic int_n = 1, reset_n = 1, stby_n = 1;
  logic int_en = 0, in_isr = 0, ext_rom = 0, osc_stable = 1, ale_tick = 0;
  logic       osc_en, cpu_clk_en, resume_valid;
  logic [6:0] float_en;
  logic [1:0] resume_kind;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pd_wake_ctrl #(.ALE_NEED(2)) dut (
    .clk(clk), .rst(rst), .op_halt(op_halt), .op_stop(op_stop),
    .op_flt(op_flt), .op_fltt(op_fltt), .op_fres(op_fres),
    .int_n(int_n), .reset_n(reset_n), .stby_n(stby_n),
    .int_en(int_en), .in_isr(in_isr), .ext_rom(ext_rom),
    .osc_stable(osc_stable), .ale_tick(ale_tick),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .float_en(float_en),
    .resume_valid(resume_valid), .resume_kind(resume_kind)
  );

  typedef struct {
    int         req;
    logic       osc;
    logic       ce;
    logic [6:0] flt;
    logic       rv;
    logic [1:0] kind;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(int r, logic osc, logic ce, logic [6:0] f,
                            logic rv, logic [1:0] k);
    exp_t e;
    e.req = r; e.osc = osc; e.ce = ce; e.flt = f; e.rv = rv; e.kind = k;
    exp_q.push_back(e);
  endtask

  task automatic ale_step();
    ale_tick = 1;
    step();
    ale_tick = 0;
  endtask

  // Monitor: pops every expectation queued since the last edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      n_cmp++;
      if (osc_en !== cur.osc || cpu_clk_en !== cur.ce || float_en !== cur.flt ||
          resume_valid !== cur.rv || (cur.rv && resume_kind !== cur.kind)) begin
        n_bad++;
        $display("FAIL R%0d: got osc=%b clk=%b flt=%h rv=%b kind=%0d, exp osc=%b clk=%b flt=%h rv=%b kind=%0d",
                 cur.req, osc_en, cpu_clk_en, float_en, resume_valid, resume_kind,
                 cur.osc, cur.ce, cur.flt, cur.rv, cur.kind);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    expect_out(1, 1, 1, 7'h00, 0, 0);                   // R1 reset state

    op_flt = 1; step(); op_flt = 0;
    expect_out(4, 1, 1, 7'h0F, 0, 0);                   // R4 internal
    op_fres = 1; step(); op_fres = 0;
    expect_out(6, 1, 1, 7'h00, 0, 0);                   // R6 cancel by opcode

    ext_rom = 1;
    op_flt = 1; step(); op_flt = 0;
    expect_out(4, 1, 1, 7'h05, 0, 0);                   // R4 external
    int_n = 0; step(); int_n = 1;
    expect_out(6, 1, 1, 7'h00, 0, 0);                   // R6 cancel by int pin
    op_fltt = 1; step(); op_fltt = 0;
    expect_out(5, 1, 1, 7'h45, 0, 0);                   // R5 external
    reset_n = 0; step(); reset_n = 1;
    expect_out(6, 1, 1, 7'h00, 0, 0);                   // R6 cancel by reset pin
    ext_rom = 0;
    op_fltt = 1; step(); op_fltt = 0;
    expect_out(5, 1, 1, 7'h7F, 0, 0);                   // R5 internal
    op_fres = 1; op_fltt = 1; step(); op_fres = 0; op_fltt = 0;
    expect_out(6, 1, 1, 7'h00, 0, 0);                   // R6 cancel beats set

    // Clock gate and interrupt wake with vectoring
    int_en = 1;
    op_halt = 1; step(); op_halt = 0;
    expect_out(2, 1, 0, 7'h00, 0, 0);                   // R2
    ale_step();
    expect_out(2, 1, 0, 7'h00, 0, 0);                   // R2 ticks alone do nothing
    int_n = 0; step();
    expect_out(7, 1, 0, 7'h00, 0, 0);                   // R7 qualifying
    ale_step();
    expect_out(7, 1, 0, 7'h00, 0, 0);                   // R7 one tick not enough
    step();
    expect_out(7, 1, 0, 7'h00, 0, 0);
    ale_step();
    expect_out(10, 1, 1, 7'h00, 1, 1);                  // R7/R10 vector
    step();
    expect_out(7, 1, 1, 7'h00, 0, 0);                   // R7 single pulse
    int_n = 1;

    // Restart of the tick count, wake inside an interrupt routine
    in_isr = 1;
    op_halt = 1; step(); op_halt = 0;
    expect_out(2, 1, 0, 7'h00, 0, 0);
    int_n = 0; step();
    ale_step();
    expect_out(8, 1, 0, 7'h00, 0, 0);
    int_n = 1; step();
    expect_out(8, 1, 0, 7'h00, 0, 0);                   // R8 back to gate
    int_n = 0; step();
    expect_out(8, 1, 0, 7'h00, 0, 0);
    ale_step();
    expect_out(8, 1, 0, 7'h00, 0, 0);                   // R8 count restarted
    ale_step();
    expect_out(10, 1, 1, 7'h00, 1, 0);                  // R10 in service -> continue
    int_n = 1; in_isr = 0; step();
    expect_out(7, 1, 1, 7'h00, 0, 0);

    // Interrupts disabled
    int_en = 0;
    op_halt = 1; step(); op_halt = 0;
    int_n = 0; step();
    ale_step();
    ale_step();
    expect_out(10, 1, 1, 7'h00, 1, 0);                  // R10 disabled -> continue
    int_n = 1; step();

    // Oscillator stop, reset wake with both pins low
    int_en = 1;
    op_stop = 1; step(); op_stop = 0;
    expect_out(3, 0, 0, 7'h00, 0, 0);                   // R3
    ale_step();
    expect_out(3, 0, 0, 7'h00, 0, 0);
    osc_stable = 0; reset_n = 0; int_n = 0; step();
    expect_out(9, 1, 0, 7'h00, 0, 0);                   // R9 oscillator restarting
    ale_step();
    expect_out(9, 1, 0, 7'h00, 0, 0);
    ale_step();
    expect_out(9, 1, 0, 7'h00, 0, 0);                   // R9 unstable ticks ignored
    osc_stable = 1;
    ale_step();
    expect_out(9, 1, 0, 7'h00, 0, 0);
    ale_step();
    expect_out(10, 1, 1, 7'h00, 1, 2);                  // R10 reset priority
    reset_n = 1; int_n = 1; step();
    expect_out(7, 1, 1, 7'h00, 0, 0);

    // Standby from run with a float selected
    op_flt = 1; step(); op_flt = 0;
    expect_out(4, 1, 1, 7'h0F, 0, 0);
    stby_n = 0; step();
    expect_out(11, 0, 0, 7'h7F, 0, 0);                  // R11
    step();
    expect_out(11, 0, 0, 7'h7F, 0, 0);
    stby_n = 1; osc_stable = 0; step();
    expect_out(11, 1, 0, 7'h7F, 0, 0);                  // R11 settling
    step();
    expect_out(11, 1, 0, 7'h7F, 0, 0);
    osc_stable = 1; step();
    expect_out(11, 1, 1, 7'h0F, 0, 0);                  // R11 back to run, float kept
    op_fres = 1; step(); op_fres = 0;
    expect_out(6, 1, 1, 7'h00, 0, 0);

    // Standby from clock gate
    op_halt = 1; step(); op_halt = 0;
    expect_out(2, 1, 0, 7'h00, 0, 0);
    stby_n = 0; step();
    expect_out(11, 0, 0, 7'h7F, 0, 0);
    stby_n = 1; step();
    expect_out(11, 1, 0, 7'h7F, 0, 0);
    step();
    expect_out(11, 1, 0, 7'h00, 0, 0);                  // R11 back to gate

    // Standby release with interrupt low
    stby_n = 0; step();
    expect_out(12, 0, 0, 7'h7F, 0, 0);
    stby_n = 1; int_n = 0; step();
    expect_out(12, 1, 0, 7'h7F, 0, 0);                  // R12 settling
    step();
    expect_out(12, 1, 0, 7'h00, 0, 0);                  // R12 qualifying
    ale_step();
    expect_out(12, 1, 0, 7'h00, 0, 0);
    ale_step();
    expect_out(12, 1, 1, 7'h00, 1, 1);                  // R12 accepted
    int_n = 1; step();
    expect_out(12, 1, 1, 7'h00, 0, 0);

    step();
    @(negedge clk);
    #1;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule